// File: doc/BRIEF.md
# Reset Cause Capture Register

This block keeps a record of which reset sources have fired since software last looked. Five sticky flags are held: power-on, release from hardware standby, watchdog expiry, external reset pin, and software reset request. Each source has its own detector. When a detector fires, it sets the matching flag. The flag then stays set until software reads the register.

The flags occupy the top five bits of one byte on a simple internal bus. The bottom three bits of the same byte are write-only watchdog control outputs. A read returns the flags and clears them on the clock edge that ends the access. A cause that fires in that same cycle wins over the clear, so no event is lost. Several causes can be latched together.

While the power-on flag is set, the other four flags carry no meaning and software must ignore them.

Top module: `rst_cause_reg`

## Requirements
- R1: After a synchronous reset, `rdata` is 0x00, `wdt_ctl` is 3'b111 and all five cause flags are 0.
- R2: A read returns the power-on flag on bit 7, standby release on bit 6, watchdog expiry on bit 5, external reset on bit 4 and software request on bit 3. Bits 2..0 always read 0.
- R3: A set flag stays 1 for any number of cycles until a read of the register.
- R4: A read (`sel` and `rd` high at a clock edge) presents on `rdata`, after that edge, the flag values held before the edge. The same edge clears the flags. In any cycle without a read, `rdata` is 0x00.
- R5: If a cause fires in the same cycle as a read, its flag is 1 after that edge. The read still returns the value held before the edge.
- R6: Causes that fire together each set their own flag.
- R7: The standby flag is set only by a low-to-high transition of `stby_pin`. A pin held high does not set the flag again after a read.
- R8: The external reset flag is set on every edge where `ext_rst_n` is low. A read during a held-low pin therefore leaves the flag set.
- R9: The watchdog, external, standby and software causes each set only their own flag and leave the other flags unchanged.
- R10: A write (`sel` and `wr` high) loads `wdt_ctl` from `wdata[2:0]`. `wdata[7:3]` has no effect on any flag.
- R11: A `por_pulse` sets the power-on flag. While that flag reads 1, the values of the other four flags are unspecified.
- R12: `rd` or `wr` without `sel` changes neither the flags nor `wdt_ctl`, and `rdata` stays 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| por_pulse | input | 1 | Power-on detection pulse, active high |
| stby_pin | input | 1 | Hardware standby pin, synchronised; a rising edge marks release |
| ext_rst_n | input | 1 | External reset pin, synchronised, active low |
| sw_rst_req | input | 1 | Software reset-request strobe |
| wdt_expire | input | 1 | Watchdog expired without a periodic clear |
| sel | input | 1 | Register select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| wdt_ctl | output | 3 | Write-only watchdog control bits (enable and two interval bits) |

## Verification
Directed sequences first raise each cause alone and then read the register. This separates bit placement and per-flag isolation from stickiness. Simultaneous watchdog and external events, a set that lands on the read-clear edge, a standby pin held high across reads, and an external pin held low across reads tell the set-over-clear priority apart from edge versus level detection. Unselected strobes and writes with the upper data bits set show that neither touches the flags. Random cycles with sparse causes and interleaved reads and writes are compared against a bench model, which masks the lower flags whenever the power-on flag is expected.

// File: rtl/rcause_pkg.sv
package rcause_pkg;
  localparam int NCAUSE = 5;
  // flag vector indices, highest bit is power-on
  localparam int IDX_POR  = 4;
  localparam int IDX_STBY = 3;
  localparam int IDX_WDOG = 2;
  localparam int IDX_EXT  = 1;
  localparam int IDX_SOFT = 0;
endpackage

// File: rtl/rcause_detect.sv
module rcause_detect
  import rcause_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              por_pulse,
  input  logic              stby_pin,
  input  logic              ext_rst_n,
  input  logic              sw_rst_req,
  input  logic              wdt_expire,
  output logic [NCAUSE-1:0] set_vec
);
  logic stby_prev;

  // previous pin level; loaded with the live level in reset so no false edge
  always_ff @(posedge clk) begin
    stby_prev <= stby_pin;
  end

  always_comb begin
    set_vec           = '0;
    set_vec[IDX_POR]  = por_pulse;
    set_vec[IDX_STBY] = stby_pin & ~stby_prev & ~rst;
    set_vec[IDX_WDOG] = wdt_expire;
    set_vec[IDX_EXT]  = ~ext_rst_n;
    set_vec[IDX_SOFT] = sw_rst_req;
  end
endmodule

// File: rtl/rcause_flags.sv
module rcause_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  output logic [N-1:0] flags_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags_q[i] <= 1'b0;
      else if (set_vec[i]) flags_q[i] <= 1'b1;  // set beats clear
      else if (clr)        flags_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcause_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        por_pulse,
  input  logic                        stby_pin,
  input  logic                        ext_rst_n,
  input  logic                        sw_rst_req,
  input  logic                        wdt_expire,
  input  logic                        sel,
  input  logic                        rd,
  input  logic                        wr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic [DATA_W-NCAUSE-1:0]    wdt_ctl
);
  localparam int CTL_W = DATA_W - NCAUSE;

  logic [NCAUSE-1:0] set_vec;
  logic [NCAUSE-1:0] flag_q;
  logic              rd_hit;
  logic              wr_hit;

  assign rd_hit = sel & rd;
  assign wr_hit = sel & wr;

  rcause_detect u_det (
    .clk        (clk),
    .rst        (rst),
    .por_pulse  (por_pulse),
    .stby_pin   (stby_pin),
    .ext_rst_n  (ext_rst_n),
    .sw_rst_req (sw_rst_req),
    .wdt_expire (wdt_expire),
    .set_vec    (set_vec)
  );

  rcause_flags #(.N(NCAUSE)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr     (rd_hit),
    .flags_q (flag_q)
  );

  // registered read path: flags on top, write-only field reads as zero
  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= {flag_q, {CTL_W{1'b0}}};
    else             rdata <= '0;
  end

  // write-only control bits, all ones out of reset
  always_ff @(posedge clk) begin
    if (rst)         wdt_ctl <= '1;
    else if (wr_hit) wdt_ctl <= wdata[CTL_W-1:0];
  end
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk
  import rcause_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wdt_expire,
  input logic                     ext_rst_n,
  input logic                     sel,
  input logic                     rd,
  input logic                     wr,
  input logic [DATA_W-1:0]        wdata,
  input logic [DATA_W-1:0]        rdata,
  input logic [DATA_W-NCAUSE-1:0] wdt_ctl,
  input logic [NCAUSE-1:0]        flags
);
  localparam int CTL_W = DATA_W - NCAUSE;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (wdt_ctl == '1 && rdata == '0 && flags == '0));

  assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (sel && rd) |=> (rdata[CTL_W-1:0] == '0));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (flags[IDX_WDOG] && !(sel && rd)) |=> flags[IDX_WDOG]);

  assert_read_value_R4: assert property (@(posedge clk) disable iff (rst)
    (sel && rd) |=> (rdata[DATA_W-1:CTL_W] == $past(flags)));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (sel && rd && wdt_expire) |=> flags[IDX_WDOG]);

  assert_ext_level_R8: assert property (@(posedge clk) disable iff (rst)
    (!ext_rst_n) |=> flags[IDX_EXT]);

  assert_ctl_write_R10: assert property (@(posedge clk) disable iff (rst)
    (sel && wr) |=> (wdt_ctl == $past(wdata[CTL_W-1:0])));

  assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (rst)
    !(sel && rd) |=> (rdata == '0));
endmodule

bind rst_cause_reg rst_cause_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wdt_expire (wdt_expire),
  .ext_rst_n  (ext_rst_n),
  .sel        (sel),
  .rd         (rd),
  .wr         (wr),
  .wdata      (wdata),
  .rdata      (rdata),
  .wdt_ctl    (wdt_ctl),
  .flags      (flag_q)
);

// File: tb/sim_rst_cause_reg.sv
`timescale 1ns/1ps
module sim_rst_cause_reg;
  logic       clk = 1'b0;
  logic       rst;
  logic       por_pulse, stby_pin, ext_rst_n, sw_rst_req, wdt_expire;
  logic       sel, rd, wr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [2:0] wdt_ctl;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [4:0] m_flags;
  logic [7:0] m_rdata;
  logic [2:0] m_ctl;
  logic       m_prev;

  always #2 clk = ~clk;

  rst_cause_reg u0 (
    .clk(clk), .rst(rst), .por_pulse(por_pulse), .stby_pin(stby_pin),
    .ext_rst_n(ext_rst_n), .sw_rst_req(sw_rst_req), .wdt_expire(wdt_expire),
    .sel(sel), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata), .wdt_ctl(wdt_ctl)
  );

  // R4: rdata shows the held flags after a read, zero otherwise
  function automatic logic [7:0] exp_read(logic [4:0] f, logic hit);
    return hit ? {f, 3'b000} : 8'h00;
  endfunction

  // R11: with power-on flagged, the lower four flags are don't-care
  function automatic logic [7:0] read_mask(logic [7:0] e);
    return e[7] ? 8'b1000_0111 : 8'hFF;
  endfunction

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp, logic [7:0] msk);
    checks++;
    if ((act & msk) !== (exp & msk)) begin
      errors++;
      $display("FAIL %s rdata act=%02h exp=%02h mask=%02h", req, act, exp, msk);
    end
  endtask

  task automatic check3(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s wdt_ctl act=%0b exp=%0b", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model, check after the edge
  task automatic step(string req);
    logic [4:0] s;
    logic       hit;
    if (rst) begin
      m_flags = '0; m_rdata = '0; m_ctl = 3'b111; m_prev = stby_pin;
    end else begin
      s   = {por_pulse, stby_pin & ~m_prev, wdt_expire, ~ext_rst_n, sw_rst_req};
      hit = sel & rd;
      m_rdata = exp_read(m_flags, hit);
      m_flags = (hit ? 5'b0 : m_flags) | s;
      if (sel && wr) m_ctl = wdata[2:0];
      m_prev = stby_pin;
    end
    @(negedge clk);
    check8(req, rdata, m_rdata, read_mask(m_rdata));
    check3(req, wdt_ctl, m_ctl);
  endtask

  task automatic idle();
    por_pulse = 0; sw_rst_req = 0; wdt_expire = 0;
    sel = 0; rd = 0; wr = 0; wdata = 8'h00;
  endtask

  task automatic do_read(string req);
    idle(); sel = 1; rd = 1;
    step(req);
    idle();
    step(req);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    idle(); stby_pin = 1; ext_rst_n = 1; rst = 1;
    @(negedge clk);
    step("R1"); step("R1");
    rst = 0;
    // R1: reset state visible at ports
    step("R1");
    check8("R1", rdata, 8'h00, 8'hFF);
    check3("R1", wdt_ctl, 3'b111);
    do_read("R1");

    // R9 / R2: each cause alone, then read
    wdt_expire = 1; step("R9"); idle(); do_read("R9");
    check8("R2", m_rdata, 8'h00, 8'hFF);
    sw_rst_req = 1; step("R9"); idle(); do_read("R9");
    ext_rst_n = 0; step("R9"); ext_rst_n = 1; step("R9"); do_read("R9");
    stby_pin = 0; step("R7"); stby_pin = 1; step("R7"); do_read("R2");

    // R3: sticky over many idle cycles
    wdt_expire = 1; step("R3"); idle();
    for (int i = 0; i < 20; i++) step("R3");
    do_read("R3");

    // R6: watchdog and external together
    wdt_expire = 1; ext_rst_n = 0; step("R6");
    idle(); ext_rst_n = 1; step("R6"); do_read("R6");

    // R5: set on the clearing edge
    wdt_expire = 1; step("R5");
    sel = 1; rd = 1; wdt_expire = 1; step("R5");
    idle(); step("R5"); do_read("R5");

    // R7: held-high standby does not re-set
    do_read("R7"); do_read("R7");

    // R8: held-low external pin keeps re-setting
    ext_rst_n = 0; step("R8"); do_read("R8"); do_read("R8");
    ext_rst_n = 1; step("R8"); do_read("R8"); do_read("R8");

    // R10: write control, upper bits ignored
    sel = 1; wr = 1; wdata = 8'hFA; step("R10"); idle(); step("R10");
    do_read("R10");
    sel = 1; wr = 1; wdata = 8'h05; step("R10"); idle(); step("R10");

    // R12: strobes without select
    wdt_expire = 1; step("R12"); idle();
    rd = 1; wr = 1; wdata = 8'h00; step("R12"); idle(); step("R12");
    do_read("R12");

    // R11: power-on
    por_pulse = 1; step("R11"); idle(); do_read("R11");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      por_pulse  = ($urandom_range(0, 99) == 0);
      wdt_expire = ($urandom_range(0, 19) == 0);
      sw_rst_req = ($urandom_range(0, 19) == 0);
      ext_rst_n  = ($urandom_range(0, 19) != 0);
      if ($urandom_range(0, 9) == 0) stby_pin = ~stby_pin;
      sel   = $urandom_range(0, 1);
      rd    = ($urandom_range(0, 2) == 0);
      wr    = ($urandom_range(0, 7) == 0);
      wdata = 8'($urandom);
      step("R4");
    end
    idle(); ext_rst_n = 1;
    do_read("R4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule